// File: doc/BRIEF.md
# Exp-Golomb Syntax Element Decoder

This block turns a packed bitstream into syntax element values. The bits arrive as 32-bit words over a valid/ready feed. A caller asks for one element at a time by pulsing `start` together with a mapping mode and a range bound. The block then decodes the next Exp-Golomb codeword in the stream. That codeword is N zero bits, a single one bit, and then N information bits. The block returns the mapped value and the number of bits it consumed, and signals completion with a one-cycle `done` pulse.

Two 32-bit registers hold the stream. A 5-bit offset records how many bits of the upper register have already been used, and a shifter turns the 64 buffered bits into a window that starts at the next unread bit. A leading-zero count on that window gives N. The value 1 followed by the N information bits, read as a binary number, is codeNum+1. When the offset passes 32, the lower word moves up and a new word is requested. A request waits until both registers hold data, so a codeword of up to 31 bits can always be seen whole.

The block supports unsigned, signed and truncated mappings. In truncated mode with a bound of 1, a single bit is read and inverted instead of a full codeword. A prefix longer than 15 zeros cannot form a codeword of at most 31 bits, so the block reports it as an error and consumes nothing.

Top module: `expg_elem_dec`

## Requirements
- R1: With mode 2'b00 (unsigned) and a codeword of N leading zeros, `len_out` is 2N+1 and `value_out` is codeNum, where codeNum+1 is the one bit followed by the N information bits read as a binary number.
- R2: With mode 2'b01 (signed), an odd codeNum k gives +(k+1)/2 and an even codeNum k gives -k/2, as a 32-bit two's complement value.
- R3: With mode 2'b10 (truncated) and `bound` greater than 1, the value and length are the same as in unsigned mode.
- R4: With mode 2'b10 and `bound` equal to 1, exactly one bit is consumed (`len_out` = 1) and `value_out` is the inverse of that bit.
- R5: Back-to-back requests decode consecutive codewords without losing or repeating bits, including codewords that straddle a 32-bit word boundary.
- R6: Each accepted `start` produces exactly one `done` pulse that lasts one cycle, with `value_out`, `len_out` and `err` valid in that cycle.
- R7: A `start` that arrives while an earlier request is still pending is ignored. A pending request stalls, with no `done`, until both buffer words hold data.
- R8: A window with more than 15 leading zeros in a codeword mode raises `err` with `done`, drives `value_out` and `len_out` to 0, and consumes no bits, so repeating the request gives the same error.
- R9: After reset `done` is 0 and `feed_ready` is 1.
- R10: `feed_ready` is 0 while both buffer words hold data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feed_data | input | 32 | Next stream word; its most significant bit comes first in the stream |
| feed_valid | input | 1 | `feed_data` is valid |
| feed_ready | output | 1 | The block can take a word this cycle |
| start | input | 1 | Request to decode one element |
| mode | input | 2 | Mapping: 00 unsigned, 01 signed, 10 truncated, 11 treated as unsigned |
| bound | input | 8 | Range bound for truncated mode |
| value_out | output | 32 | Decoded element value |
| len_out | output | 6 | Bits consumed by this element |
| err | output | 1 | Prefix too long (valid with `done`) |
| done | output | 1 | One-cycle pulse: result valid |

## Verification
The assertions check on every cycle the properties that hold for any element. `done` never lasts two cycles. A successful codeword length is odd and at most 31. An error result carries a length of 0. A bound-1 truncated result is one bit long with a value of 0 or 1. A start that arrives while a request is pending leaves the latched mode unchanged, and `feed_ready` stays low while the buffer is full.

Only the bench scenarios can show that the values are correct. To do this, they sweep codeNum for each mapping and pack the codewords into one continuous stream, so that many codewords straddle word boundaries and the offset and refill path are exercised. They also hold back the feed so that a pending request has to stall. Finally, they reach an over-long prefix twice in a row, which shows that nothing was consumed.

// File: rtl/expg_pkg.sv
package expg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 6;
  localparam int unsigned OFS_W  = 5;
  localparam int unsigned MAX_LZ = 15;

  typedef enum logic [1:0] {
    EG_UNS = 2'b00,
    EG_SGN = 2'b01,
    EG_TRC = 2'b10,
    EG_ALT = 2'b11
  } eg_mode_e;
endpackage

// File: rtl/expg_bitbuf.sv
module expg_bitbuf
  import expg_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             take,
  input  logic [LEN_W-1:0] take_len,
  output logic [W-1:0]     window,
  output logic             full
);
  localparam int unsigned PAIR_W = 2 * W;

  logic [W-1:0]      upper_q, lower_q;
  logic              upper_v, lower_v;
  logic [OFS_W-1:0]  ofs_q;
  logic [PAIR_W-1:0] pair_sh;
  logic [LEN_W-1:0]  sum;

  assign in_ready = !lower_v;
  assign full     = upper_v && lower_v;
  assign pair_sh  = {upper_q, lower_q} << ofs_q;
  assign window   = pair_sh[PAIR_W-1 -: W];
  assign sum      = LEN_W'(ofs_q) + take_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      lower_q <= '0;
      upper_v <= 1'b0;
      lower_v <= 1'b0;
      ofs_q   <= '0;
    end else begin
      if (in_valid && in_ready) begin
        if (!upper_v) begin
          upper_q <= in_data;
          upper_v <= 1'b1;
        end else begin
          lower_q <= in_data;
          lower_v <= 1'b1;
        end
      end
      if (take && full) begin
        ofs_q <= sum[OFS_W-1:0];
        if (sum[LEN_W-1]) begin
          upper_q <= lower_q;
          lower_v <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/expg_lzd.sv
module expg_lzd #(
  parameter int unsigned W   = 32,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     bits,
  output logic [CNT_W-1:0] zeros
);
  always_comb begin
    zeros = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (bits[i]) zeros = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/expg_map.sv
module expg_map
  import expg_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned BND_W = 8
) (
  input  logic [W-1:0]     window,
  input  logic [LEN_W-1:0] zeros,
  input  logic [1:0]       mode,
  input  logic [BND_W-1:0] bound,
  output logic [W-1:0]     value,
  output logic [LEN_W-1:0] len,
  output logic             bad
);
  logic [OFS_W-1:0] shamt;
  logic [W-1:0]     code_p1, code_num, half;
  logic             one_bit;

  assign one_bit  = (eg_mode_e'(mode) == EG_TRC) && (bound == BND_W'(1));
  assign shamt    = OFS_W'(W - 1) - {zeros[3:0], 1'b0};
  assign code_p1  = window >> shamt;
  assign code_num = code_p1 - W'(1);
  assign half     = code_p1 >> 1;

  always_comb begin
    value = '0;
    len   = '0;
    bad   = 1'b0;
    if (one_bit) begin
      value = W'(!window[W-1]);
      len   = LEN_W'(1);
    end else if (zeros > LEN_W'(MAX_LZ)) begin
      bad = 1'b1;
    end else begin
      len = {zeros[4:0], 1'b1};
      if (eg_mode_e'(mode) == EG_SGN) begin
        value = code_num[0] ? half : (W'(0) - half);
      end else begin
        value = code_num;
      end
    end
  end
endmodule

// File: rtl/expg_elem_dec.sv
module expg_elem_dec
  import expg_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned BND_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     feed_data,
  input  logic             feed_valid,
  output logic             feed_ready,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [BND_W-1:0] bound,
  output logic [W-1:0]     value_out,
  output logic [LEN_W-1:0] len_out,
  output logic             err,
  output logic             done
);
  localparam int unsigned ZC_W = $clog2(W + 1);

  logic             pend_q;
  logic [1:0]       mode_q;
  logic [BND_W-1:0] bound_q;
  logic [W-1:0]     window;
  logic             full, go;
  logic [ZC_W-1:0]  zeros;
  logic [W-1:0]     val_c;
  logic [LEN_W-1:0] len_c;
  logic             bad_c;

  assign go = pend_q && full;

  expg_bitbuf #(.W(W)) u_buf (
    .clk(clk), .rst(rst),
    .in_data(feed_data), .in_valid(feed_valid), .in_ready(feed_ready),
    .take(go && !bad_c), .take_len(len_c),
    .window(window), .full(full)
  );

  expg_lzd #(.W(W), .CNT_W(ZC_W)) u_lzd (
    .bits(window), .zeros(zeros)
  );

  expg_map #(.W(W), .BND_W(BND_W)) u_map (
    .window(window), .zeros(LEN_W'(zeros)), .mode(mode_q), .bound(bound_q),
    .value(val_c), .len(len_c), .bad(bad_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      mode_q    <= '0;
      bound_q   <= '0;
      value_out <= '0;
      len_out   <= '0;
      err       <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= go;
      if (go) begin
        pend_q    <= 1'b0;
        value_out <= val_c;
        len_out   <= len_c;
        err       <= bad_c;
      end else if (start && !pend_q) begin
        pend_q  <= 1'b1;
        mode_q  <= mode;
        bound_q <= bound;
      end
    end
  end
endmodule

// File: rtl/expg_elem_dec_chk.sv
module expg_elem_dec_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned BND_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic             err,
  input logic [5:0]       len_out,
  input logic [W-1:0]     value_out,
  input logic             feed_ready,
  input logic             busy,
  input logic             full,
  input logic [1:0]       mode_q,
  input logic [BND_W-1:0] bound_q
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  odd_len_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (len_out[0] && len_out <= 6'd31));
  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (len_out == 6'd0 && value_out == '0));
  // R4
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == 2'b10 && bound_q == BND_W'(1)) |-> (len_out == 6'd1 && value_out <= W'(1) && !err));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mode_q) && $stable(bound_q)));
  // R10
  full_ready_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !feed_ready);
endmodule

bind expg_elem_dec expg_elem_dec_chk #(.W(W), .BND_W(BND_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .err(err),
  .len_out(len_out), .value_out(value_out), .feed_ready(feed_ready),
  .busy(pend_q), .full(full), .mode_q(mode_q), .bound_q(bound_q)
);

// File: tb/sim_expg_elem_dec.sv
`timescale 1ns/1ps
module sim_expg_elem_dec;
  localparam int NWORDS = 512;
  localparam int NELEM  = 512;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] feed_data = '0;
  logic        feed_valid = 0;
  logic        feed_ready;
  logic        start = 0;
  logic [1:0]  mode = 0;
  logic [7:0]  bound = 0;
  logic [31:0] value_out;
  logic [5:0]  len_out;
  logic        err, done;

  always #4 clk = ~clk;

  expg_elem_dec u0 (
    .clk(clk), .rst(rst), .feed_data(feed_data), .feed_valid(feed_valid),
    .feed_ready(feed_ready), .start(start), .mode(mode), .bound(bound),
    .value_out(value_out), .len_out(len_out), .err(err), .done(done)
  );

  logic [31:0] mem [NWORDS];
  int          bitp = 0;
  logic [1:0]  e_mode  [NELEM];
  logic [7:0]  e_bound [NELEM];
  logic [31:0] e_val   [NELEM];
  int          e_len   [NELEM];
  int          n_elem = 0;

  int  n_cmp = 0, n_bad = 0, n_done = 0, cyc = 0;
  bit  feed_en = 0, rdy_s = 0, finished = 0;
  int  widx = 0;

  task automatic put_bit(input bit b);
    mem[bitp >> 5][31 - (bitp & 31)] = b;
    bitp++;
  endtask

  task automatic add_code(input logic [1:0] m, input logic [7:0] bd, input int k, input logic [31:0] ev);
    int n = 0;
    while (((k + 1) >> (n + 1)) != 0) n++;
    for (int i = 0; i < n; i++) put_bit(1'b0);
    for (int i = n; i >= 0; i--) put_bit(((k + 1) >> i) & 1);
    e_mode[n_elem] = m; e_bound[n_elem] = bd; e_val[n_elem] = ev; e_len[n_elem] = 2 * n + 1;
    n_elem++;
  endtask

  task automatic add_bit(input bit b);
    put_bit(b);
    e_mode[n_elem] = 2'b10; e_bound[n_elem] = 8'd1; e_val[n_elem] = {31'd0, ~b}; e_len[n_elem] = 1;
    n_elem++;
  endtask

  function automatic logic [31:0] sgn(input int k);
    return (k % 2 == 1) ? 32'((k + 1) / 2) : 32'(-(k / 2));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // feeder: acceptance judged from ready sampled one negedge earlier
  always @(negedge clk) begin
    if (feed_valid && rdy_s && widx < NWORDS - 1) widx++;
    rdy_s = feed_ready;
    feed_valid = feed_en;
    feed_data = mem[widx];
  end

  always @(negedge clk) if (!rst && done) n_done++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] m, input logic [7:0] bd);
    @(negedge clk); start = 1; mode = m; bound = bd;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int t = 0; t < 200; t++) begin
      if (done) begin ok = 1; return; end
      @(negedge clk);
    end
  endtask

  initial begin
    bit ok;
    int d0;
    for (int i = 0; i < NWORDS; i++) mem[i] = '0;
    // element 0: unsigned codeNum 5 (00110)
    add_code(2'b00, 8'd0, 5, 32'd5);
    for (int k = 0; k < 256; k++) add_code(2'b00, 8'd0, k, 32'(k));          // R1
    add_code(2'b00, 8'd0, 65534, 32'd65534);
    add_code(2'b11, 8'd0, 32767, 32'd32767);
    for (int k = 0; k < 128; k++) add_code(2'b01, 8'd0, k, sgn(k));           // R2
    add_code(2'b01, 8'd0, 65534, sgn(65534));
    add_code(2'b01, 8'd0, 65533, sgn(65533));
    for (int k = 0; k < 12; k++) add_code(2'b10, 8'(2 + k % 5), k, 32'(k));   // R3
    for (int k = 0; k < 8; k++) add_bit(k[0] ^ k[2]);                         // R4
    add_code(2'b10, 8'd9, 3, 32'd3);
    // remaining stream is zeros: over-long prefix for R8

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 done", {31'd0, done}, 32'd0);
    chk("R9 feed_ready", {31'd0, feed_ready}, 32'd1);

    // R7: pending request with an empty buffer stalls; extra starts ignored
    issue(2'b00, 8'd0);
    issue(2'b10, 8'd1);
    issue(2'b01, 8'd0);
    repeat (4) @(negedge clk);
    chk("R7 no done while stalled", 32'(n_done), 32'd0);
    feed_en = 1;
    wait_done(ok);
    chk("R7 done after refill", {31'd0, ok}, 32'd1);
    chk("R7 first value", value_out, 32'd5);
    chk("R7 first len", {26'd0, len_out}, 32'd5);
    repeat (5) @(negedge clk);
    chk("R6 single done", 32'(n_done), 32'd1);
    chk("R10 ready low when full", {31'd0, feed_ready}, 32'd0);

    for (int e = 1; e < n_elem; e++) begin
      d0 = n_done;
      issue(e_mode[e], e_bound[e]);
      wait_done(ok);
      chk("R5 done seen", {31'd0, ok}, 32'd1);
      case (e_mode[e])
        2'b01:   chk("R2 value", value_out, e_val[e]);
        2'b10:   chk(e_bound[e] == 8'd1 ? "R4 value" : "R3 value", value_out, e_val[e]);
        default: chk("R1 value", value_out, e_val[e]);
      endcase
      chk("R1 R5 len", {26'd0, len_out}, 32'(e_len[e]));
      chk("R8 no err", {31'd0, err}, 32'd0);
      @(negedge clk);
      chk("R6 one pulse", 32'(n_done - d0), 32'd1);
    end

    for (int r = 0; r < 2; r++) begin
      issue(2'b00, 8'd0);
      wait_done(ok);
      chk("R8 done", {31'd0, ok}, 32'd1);
      chk("R8 err", {31'd0, err}, 32'd1);
      chk("R8 len", {26'd0, len_out}, 32'd0);
      chk("R8 value", value_out, 32'd0);
      @(negedge clk);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule